// File: doc/BRIEF.md
# Touch ADC Conversion Sequencer

This block decides when a touch-screen converter takes a sample and records which results are waiting to be read. A host writes a configuration word that picks the next conversion function and its precision, and that enables or disables the sequencer. When the conditions that the chosen function imposes are met, the sequencer runs a conversion of fixed length. At the end it raises a set of data-ready flags that depend on the function. Each flag drops when the host reads the matching result register. The measured value itself is not produced here. It arrives on `sample_in`, and the block only truncates it to the active precision when a result is read.

A small state machine has two states, `S_IDLE` and `S_CONV`. Transition `T_START` goes from `S_IDLE` to `S_CONV` when a conversion may begin. `T_DONE` returns to `S_IDLE` after the last conversion cycle and raises the function's flags. `T_ABORT` returns to `S_IDLE` early, with no flags, when the sequencer is disabled or soft-reset. An active-low interrupt pin reports pen contact, pending data, or pen contact with nothing pending, as selected by a programmable mode. Writing a fixed key word to the reset slot returns the sequencer to its idle defaults.

Registers are reached through a flat access port. Page 0 holds the result registers and page 1 holds control. Writes take effect at the clock edge. Reads return data combinationally in the same cycle, and a result read clears its flag at that cycle's edge.

Top module: `touch_conv_seq`

## Requirements
- R1: After reset the sequencer is disabled and idle, no data flag is set, the pin mode is 2, `pen_irq_n` is high, and next function, next precision, filter and host bit are all 0.
- R2: A write to page 1 offset 0 loads host (bit 15), disable (bit 14, 1 = disabled), next function (bits 13:10), next precision (bits 9:8) and filter (bits 7:0). A read of that offset returns pen (bit 15), not-busy (bit 14), then next function, next precision and filter in the same positions.
- R3: In `S_IDLE`, a conversion starts (`T_START`) only when the sequencer is enabled, no data flag is set and the function's start rule holds. Starting latches the next function and precision as active. The sequencer stays busy for exactly CONV_CYCLES cycles and then ORs the active function's mask into the flags. The masks are: X 0x400, Y 0x200, Z 0x180, XY 0x600, XYZ 0x780, BAT1 0x040, BAT2 0x030, AUX and AUX-scan 0x010, TEMP1 0x004, TEMP2 0x002, port scan 0x070.
- R4: Functions 1 to 5 (XY, XYZ, X, Y, Z) start only while `pen_down` is high.
- R5: Functions 0, 13, 14 and 15 never start. Functions 9 and 11 start regardless of the pen.
- R6: While any flag is set, functions 6, 7, 8, 10 and 12 clear the enable. Functions 3 to 5 do the same only while the pen is down. A one-shot conversion therefore does not repeat.
- R7: A read on page 0 at offsets 0, 1, 2, 3, 5, 6, 7, 9 and 10 returns `sample_in` shifted right by 16 minus the result width, and clears flag bit 10, 9, 8, 7, 6, 5, 4, 2 and 1 respectively. The result width is 12, 8, 10 or 12 bits for active precision code 0, 1, 2 or 3. Changing the next precision after a conversion does not alter its results.
- R8: Page 0 offsets 8 and 11 read 0xFFFF and clear flag bits 3 and 0. Every other unmapped offset or page reads 0xFFFF.
- R9: Page 1 offset 1 reads pin mode (bits 15:14), not-enabled (bit 13), host (bit 12), any-flag (bit 11) and the flags (bits 10:0). A write to it sets the pin mode from bits 15:14.
- R10: The pin is asserted when the pen is down (mode 0), when any flag is set (mode 1), or when the pen is down with no flag set (modes 2 and 3). It is forced inactive while the sequencer is disabled and is driven active low.
- R11: Writing 0xBB00 to page 1 offset 4 cancels any conversion, clears all flags, disables the sequencer, sets next function to 0 and pin mode to 2, and keeps next precision, filter and host.
- R12: Writing any other value to page 1 offset 4 has no effect.
- R13: Disabling the sequencer while a conversion is running aborts it (`T_ABORT`) and sets no flag.
- R14: A repeating function restarts as soon as all flags have been read clear, provided its start rule still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pen_down | input | 1 | Pen contact, synchronous to clk |
| sample_in | input | DATA_W | Raw measurement from the converter |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears result flags) |
| page | input | 2 | Register page: 0 results, 1 control |
| offset | input | 6 | Register offset within the page |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the cycle of rd_en |
| pen_irq_n | output | 1 | Active-low pen/data interrupt |

## Verification
The bench targets the ordering between flags and starts. A scan function that still held pending flags but restarted anyway would overwrite data and show busy too early. A one-shot function that failed to disable itself would run again after its result was read. An abort that let the counter finish would leave stray flag bits in the status word. It also checks that a result read after the next precision has been rewritten still uses the width latched at start. A design that read the live field would return a differently shifted value. Further checks cover the wrong reset key, which must leave a running conversion busy, and the right key, which must clear flags while keeping precision and filter. Finally, the bench checks that the interrupt pin stays high in every mode while the sequencer is disabled.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    localparam int REG_W  = 16;
    localparam int OFF_W  = 6;
    localparam int DAV_W  = 11;

    localparam logic [1:0]       PG_RESULT   = 2'd0;
    localparam logic [1:0]       PG_CONTROL  = 2'd1;
    localparam logic [OFF_W-1:0] OFF_CONFIG  = 6'd0;
    localparam logic [OFF_W-1:0] OFF_STATUS  = 6'd1;
    localparam logic [OFF_W-1:0] OFF_RESET   = 6'd4;
    localparam logic [REG_W-1:0] SOFT_RESET_KEY = 16'hBB00;

    typedef enum logic [3:0] {
        FN_NONE     = 4'd0,  FN_XY      = 4'd1,  FN_XYZ     = 4'd2,
        FN_X        = 4'd3,  FN_Y       = 4'd4,  FN_Z       = 4'd5,
        FN_BAT1     = 4'd6,  FN_BAT2    = 4'd7,  FN_AUX     = 4'd8,
        FN_AUX_SCAN = 4'd9,  FN_TEMP1   = 4'd10, FN_PORT_SCAN = 4'd11,
        FN_TEMP2    = 4'd12, FN_DRV_XX  = 4'd13, FN_DRV_YY  = 4'd14,
        FN_DRV_YX   = 4'd15
    } func_e;

    typedef enum logic [2:0] {
        GATE_NEVER, GATE_PEN, GATE_PEN_ONCE, GATE_ONCE, GATE_FREE
    } gate_e;

    typedef enum logic [1:0] {
        PIN_PEN = 2'd0, PIN_DATA = 2'd1, PIN_PEN_IDLE = 2'd2, PIN_ALT = 2'd3
    } pin_mode_e;

    typedef enum logic {S_IDLE = 1'b0, S_CONV = 1'b1} conv_state_e;

    function automatic logic [DAV_W-1:0] dav_mask(input func_e f);
        case (f)
            FN_X:         return 11'h400;
            FN_Y:         return 11'h200;
            FN_Z:         return 11'h180;
            FN_XY:        return 11'h600;
            FN_XYZ:       return 11'h780;
            FN_BAT1:      return 11'h040;
            FN_BAT2:      return 11'h030;
            FN_AUX:       return 11'h010;
            FN_AUX_SCAN:  return 11'h010;
            FN_TEMP1:     return 11'h004;
            FN_PORT_SCAN: return 11'h070;
            FN_TEMP2:     return 11'h002;
            default:      return '0;
        endcase
    endfunction

    function automatic gate_e start_gate(input func_e f);
        case (f)
            FN_XY, FN_XYZ:                       return GATE_PEN;
            FN_X, FN_Y, FN_Z:                    return GATE_PEN_ONCE;
            FN_BAT1, FN_BAT2, FN_AUX,
            FN_TEMP1, FN_TEMP2:                  return GATE_ONCE;
            FN_AUX_SCAN, FN_PORT_SCAN:           return GATE_FREE;
            default:                             return GATE_NEVER;
        endcase
    endfunction

    function automatic logic [4:0] result_bits(input logic [1:0] prec);
        case (prec)
            2'd1:    return 5'd8;
            2'd2:    return 5'd10;
            default: return 5'd12;
        endcase
    endfunction

    // Flag bit released by a read of each result offset
    function automatic logic [DAV_W-1:0] read_clear(input logic [OFF_W-1:0] off);
        case (off)
            6'd0:    return 11'h400;
            6'd1:    return 11'h200;
            6'd2:    return 11'h100;
            6'd3:    return 11'h080;
            6'd5:    return 11'h040;
            6'd6:    return 11'h020;
            6'd7:    return 11'h010;
            6'd8:    return 11'h008;
            6'd9:    return 11'h004;
            6'd10:   return 11'h002;
            6'd11:   return 11'h001;
            default: return '0;
        endcase
    endfunction

    function automatic logic has_result(input logic [OFF_W-1:0] off);
        return (read_clear(off) != '0) && (off != 6'd8) && (off != 6'd11);
    endfunction

endpackage

// File: rtl/tcs_ctrl_regs.sv
module tcs_ctrl_regs
    import tcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         page,
    input  logic [OFF_W-1:0]   offset,
    input  logic [REG_W-1:0]   wdata,
    input  logic               oneshot_off,
    output logic               soft_rst,
    output logic               host_mode,
    output logic               enabled,
    output func_e              next_func,
    output logic [1:0]         next_prec,
    output logic [7:0]         filter,
    output pin_mode_e          pin_mode
);

    logic cfg_wr;
    logic pin_wr;

    always_comb begin
        cfg_wr   = wr_en && (page == PG_CONTROL) && (offset == OFF_CONFIG);
        pin_wr   = wr_en && (page == PG_CONTROL) && (offset == OFF_STATUS);
        soft_rst = wr_en && (page == PG_CONTROL) && (offset == OFF_RESET)
                   && (wdata == SOFT_RESET_KEY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_mode <= 1'b0;
            enabled   <= 1'b0;
            next_func <= FN_NONE;
            next_prec <= 2'd0;
            filter    <= 8'd0;
            pin_mode  <= PIN_PEN_IDLE;
        end else if (soft_rst) begin
            enabled   <= 1'b0;
            next_func <= FN_NONE;
            pin_mode  <= PIN_PEN_IDLE;
        end else begin
            if (cfg_wr) begin
                host_mode <= wdata[15];
                enabled   <= ~wdata[14];
                next_func <= func_e'(wdata[13:10]);
                next_prec <= wdata[9:8];
                filter    <= wdata[7:0];
            end else if (oneshot_off) begin
                enabled   <= 1'b0;
            end
            if (pin_wr) begin
                pin_mode  <= pin_mode_e'(wdata[15:14]);
            end
        end
    end

endmodule

// File: rtl/tcs_conv_fsm.sv
module tcs_conv_fsm
    import tcs_pkg::*;
#(
    parameter int CONV_CYCLES = 48828
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enabled,
    input  logic        pen_down,
    input  logic        dav_any,
    input  logic        soft_rst,
    input  func_e       next_func,
    input  logic [1:0]  next_prec,
    output logic        busy,
    output logic        done,
    output logic        oneshot_off,
    output func_e       act_func,
    output logic [1:0]  act_prec
);

    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

    conv_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    gate_e             gate;
    logic              rule_ok;
    logic              start_ok;
    logic              last_cycle;

    always_comb begin
        gate = start_gate(next_func);
        unique case (gate)
            GATE_PEN, GATE_PEN_ONCE: rule_ok = pen_down;
            GATE_ONCE, GATE_FREE:    rule_ok = 1'b1;
            default:                 rule_ok = 1'b0;
        endcase
        start_ok   = enabled && !dav_any && !soft_rst && rule_ok;
        last_cycle = (cnt_q == CNT_LAST);
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_ok) state_d = S_CONV;              // T_START
            S_CONV: begin
                if (soft_rst || !enabled) state_d = S_IDLE;      // T_ABORT
                else if (last_cycle)      state_d = S_IDLE;      // T_DONE
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        busy        = 1'b0;
        done        = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_CONV: begin
                busy = 1'b1;
                done = enabled && !soft_rst && last_cycle;
            end
            default: ;
        endcase
        oneshot_off = enabled && dav_any &&
                      ((gate == GATE_ONCE) || ((gate == GATE_PEN_ONCE) && pen_down));
    end

    // Counter and latched function
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            act_func <= FN_NONE;
            act_prec <= 2'd0;
        end else begin
            if (state_q == S_CONV) cnt_q <= cnt_q + 1'b1;
            else                   cnt_q <= '0;
            if (state_q == S_IDLE && start_ok) begin
                act_func <= next_func;
                act_prec <= next_prec;
            end
        end
    end

endmodule

// File: rtl/tcs_dav_track.sv
module tcs_dav_track
    import tcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              done,
    input  func_e             act_func,
    input  logic              rd_en,
    input  logic [1:0]        page,
    input  logic [OFF_W-1:0]  offset,
    output logic [DAV_W-1:0]  dav
);

    logic [DAV_W-1:0] clr_mask;
    logic [DAV_W-1:0] set_mask;

    always_comb begin
        clr_mask = (rd_en && page == PG_RESULT) ? read_clear(offset) : '0;
        set_mask = done ? dav_mask(act_func) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        dav <= '0;
        else if (soft_rst) dav <= '0;
        else               dav <= (dav & ~clr_mask) | set_mask;
    end

endmodule

// File: rtl/touch_conv_seq.sv
module touch_conv_seq
    import tcs_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 48828
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pen_down,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        page,
    input  logic [5:0]        offset,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              pen_irq_n
);

    logic             soft_rst;
    logic             host_mode;
    logic             enabled;
    func_e            next_func;
    logic [1:0]       next_prec;
    logic [7:0]       filter;
    pin_mode_e        pin_mode;
    logic             busy;
    logic             done;
    logic             oneshot_off;
    func_e            act_func;
    logic [1:0]       act_prec;
    logic [DAV_W-1:0] dav;
    logic             dav_any;
    logic             pin_act;
    int unsigned      shift;

    assign dav_any = |dav;

    tcs_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .page(page), .offset(offset),
        .wdata(wdata), .oneshot_off(oneshot_off), .soft_rst(soft_rst),
        .host_mode(host_mode), .enabled(enabled), .next_func(next_func),
        .next_prec(next_prec), .filter(filter), .pin_mode(pin_mode)
    );

    tcs_conv_fsm #(.CONV_CYCLES(CONV_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enabled(enabled), .pen_down(pen_down),
        .dav_any(dav_any), .soft_rst(soft_rst), .next_func(next_func),
        .next_prec(next_prec), .busy(busy), .done(done),
        .oneshot_off(oneshot_off), .act_func(act_func), .act_prec(act_prec)
    );

    tcs_dav_track u_dav (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .done(done),
        .act_func(act_func), .rd_en(rd_en), .page(page), .offset(offset),
        .dav(dav)
    );

    // Read mux
    always_comb begin
        shift = DATA_W - int'(result_bits(act_prec));
        rdata = '1;
        if (page == PG_RESULT) begin
            if (has_result(offset)) rdata = REG_W'(sample_in >> shift);
        end else if (page == PG_CONTROL) begin
            if (offset == OFF_CONFIG)
                rdata = {pen_down, ~busy, next_func, next_prec, filter};
            else if (offset == OFF_STATUS)
                rdata = {pin_mode, ~enabled, host_mode, dav_any, dav};
        end
    end

    // Interrupt pin
    always_comb begin
        unique case (pin_mode)
            PIN_PEN:               pin_act = pen_down;
            PIN_DATA:              pin_act = dav_any;
            PIN_PEN_IDLE, PIN_ALT: pin_act = pen_down && !dav_any;
        endcase
        pen_irq_n = !(pin_act && enabled);
    end

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker
    import tcs_pkg::*;
#(
    parameter int CONV_CYCLES = 48828
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pen_down,
    input logic             pen_irq_n,
    input logic             busy,
    input logic             enabled,
    input logic             soft_rst,
    input logic [DAV_W-1:0] dav,
    input func_e            act_func,
    input pin_mode_e        pin_mode
);

    int unsigned busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    a_r3_flags_follow_conv: assert property (@(posedge clk) disable iff (!rst_n)
        ((dav & ~$past(dav)) != '0) |-> $past(busy));

    a_r3_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= CONV_CYCLES);

    a_r3_start_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(enabled) && ($past(dav) == '0)));

    a_r4_pen_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && (act_func >= FN_XY) && (act_func <= FN_Z)) |-> $past(pen_down));

    a_r5_never_funcs: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((act_func != FN_NONE) && (act_func < FN_DRV_XX)));

    a_r10_pin_forced: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |-> pen_irq_n);

    a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy && (dav == '0) && !enabled && (pin_mode == PIN_PEN_IDLE)));

    a_r13_abort_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !enabled) |=> (!busy && ((dav & ~$past(dav)) == '0)));

endmodule

bind touch_conv_seq tcs_checker #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .pen_down(pen_down), .pen_irq_n(pen_irq_n),
    .busy(busy), .enabled(enabled), .soft_rst(soft_rst), .dav(dav),
    .act_func(act_func), .pin_mode(pin_mode)
);

// File: tb/touch_conv_seq_tb.sv
module touch_conv_seq_tb;

    localparam int DATA_W = 16;
    localparam int CONV   = 8;
    localparam int WAIT_N = CONV + 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pen_down = 1'b0;
    logic [DATA_W-1:0] sample_in = 16'hABCD;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [1:0]        page = 2'd0;
    logic [5:0]        offset = 6'd0;
    logic [15:0]       wdata = 16'd0;
    logic [15:0]       rdata;
    logic              pen_irq_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    event        rd_evt;

    always #10 clk = ~clk;

    touch_conv_seq #(.DATA_W(DATA_W), .CONV_CYCLES(CONV)) u_dut (
        .clk(clk), .rst_n(rst_n), .pen_down(pen_down), .sample_in(sample_in),
        .wr_en(wr_en), .rd_en(rd_en), .page(page), .offset(offset),
        .wdata(wdata), .rdata(rdata), .pen_irq_n(pen_irq_n)
    );

    // Monitor: pops the expected item when a read is sampled
    initial forever begin
        @(rd_evt);
        begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                errors++;
                $display("FAIL %s: read got %h expected %h", t, rdata, e);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] pg, input logic [5:0] off, input logic [15:0] d);
        wr_en = 1'b1; page = pg; offset = off; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] pg, input logic [5:0] off,
                            input logic [15:0] exp, input string tag);
        rd_en = 1'b1; page = pg; offset = off;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        #5;
        -> rd_evt;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pin_check(input logic exp, input string tag);
        #1;
        checks++;
        if (pen_irq_n !== exp) begin
            errors++;
            $display("FAIL %s: pen_irq_n got %b expected %b", tag, pen_irq_n, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_check(2'd1, 6'd0, 16'h4000, "R1 config readback");
        rd_check(2'd1, 6'd1, 16'hA000, "R1 status readback");
        pin_check(1'b1, "R1 pin idle");
        tick(1);

        // R2 field write and readback, R9 host bit
        wr(2'd1, 6'd0, 16'hC25A);
        rd_check(2'd1, 6'd0, 16'h425A, "R2 config fields");
        rd_check(2'd1, 6'd1, 16'hB000, "R9 host and disable bits");

        // R5 functions that never start
        wr(2'd1, 6'd0, 16'h0000);
        tick(WAIT_N);
        rd_check(2'd1, 6'd0, 16'h4000, "R5 function 0 idle");
        wr(2'd1, 6'd0, 16'h3400);
        tick(WAIT_N);
        rd_check(2'd1, 6'd0, 16'h7400, "R5 function 13 idle");
        rd_check(2'd1, 6'd1, 16'h8000, "R5 no flags");

        // R4 pen-gated XY scan, precision code 1
        wr(2'd1, 6'd0, 16'h0500);
        tick(WAIT_N);
        rd_check(2'd1, 6'd0, 16'h4500, "R4 no start without pen");
        pin_check(1'b1, "R10 mode2 pen up");
        tick(1);
        pen_down = 1'b1;
        pin_check(1'b0, "R10 mode2 pen down no data");
        tick(2);
        rd_check(2'd1, 6'd0, 16'h8500, "R4 busy with pen");
        tick(WAIT_N);
        rd_check(2'd1, 6'd1, 16'h8E00, "R3 XY mask");
        pin_check(1'b1, "R10 mode2 data pending");
        tick(1);
        rd_check(2'd0, 6'd0, 16'h00AB, "R7 X result 8 bit");
        rd_check(2'd1, 6'd1, 16'h8A00, "R7 X read clears bit 10");
        rd_check(2'd0, 6'd1, 16'h00AB, "R7 Y result 8 bit");
        tick(1);
        rd_check(2'd1, 6'd0, 16'h8500, "R14 restart after clear");
        pen_down = 1'b0;
        tick(WAIT_N);
        rd_check(2'd1, 6'd1, 16'h8E00, "R3 XY mask second run");
        wr(2'd1, 6'd1, 16'h4000);
        pin_check(1'b0, "R10 mode1 data pending");
        tick(1);
        wr(2'd1, 6'd1, 16'h0000);
        pin_check(1'b1, "R10 mode0 pen up");
        tick(1);
        pen_down = 1'b1;
        pin_check(1'b0, "R10 mode0 pen down");
        tick(1);
        pen_down = 1'b0;
        rd_check(2'd0, 6'd0, 16'h00AB, "R7 X clear");
        rd_check(2'd0, 6'd1, 16'h00AB, "R7 Y clear");

        // R13 abort while busy
        wr(2'd1, 6'd0, 16'h2400);
        tick(1);
        rd_check(2'd1, 6'd0, 16'h2400, "R5 aux scan starts without pen");
        wr(2'd1, 6'd0, 16'h6400);
        tick(WAIT_N);
        rd_check(2'd1, 6'd1, 16'h2000, "R13 abort leaves no flags");
        rd_check(2'd1, 6'd0, 16'h6400, "R13 idle after abort");

        // R3 aux scan completes, R14 restart
        wr(2'd1, 6'd0, 16'h2400);
        tick(WAIT_N);
        rd_check(2'd1, 6'd1, 16'h0810, "R3 aux scan mask");
        rd_check(2'd0, 6'd7, 16'h0ABC, "R7 aux result 12 bit");
        tick(1);
        rd_check(2'd1, 6'd0, 16'h2400, "R14 scan restarts");
        wr(2'd1, 6'd0, 16'h6400);
        tick(WAIT_N);
        rd_check(2'd1, 6'd1, 16'h2000, "R13 second abort");

        // R6 one-shot BAT1, precision code 2
        wr(2'd1, 6'd0, 16'h1A00);
        tick(WAIT_N);
        rd_check(2'd1, 6'd1, 16'h2840, "R6 one-shot disables");
        rd_check(2'd0, 6'd5, 16'h02AF, "R7 BAT1 result 10 bit");
        rd_check(2'd1, 6'd1, 16'h2000, "R7 BAT1 clears bit 6");
        tick(WAIT_N);
        rd_check(2'd1, 6'd1, 16'h2000, "R6 no repeat");
        pen_down = 1'b1;
        pin_check(1'b1, "R10 forced inactive when disabled");
        tick(1);
        pen_down = 1'b0;

        // R8 unmapped reads
        rd_check(2'd0, 6'd8, 16'hFFFF, "R8 offset 8");
        rd_check(2'd0, 6'd4, 16'hFFFF, "R8 offset 4");
        rd_check(2'd0, 6'd12, 16'hFFFF, "R8 offset 12");
        rd_check(2'd1, 6'd4, 16'hFFFF, "R8 control offset 4");
        rd_check(2'd2, 6'd0, 16'hFFFF, "R8 page 2");

        // R12 wrong key, R11 soft reset
        wr(2'd1, 6'd1, 16'h4000);
        wr(2'd1, 6'd0, 16'h2F11);
        tick(1);
        rd_check(2'd1, 6'd0, 16'h2F11, "R12 busy before key");
        wr(2'd1, 6'd4, 16'h1234);
        rd_check(2'd1, 6'd0, 16'h2F11, "R12 wrong key ignored");
        rd_check(2'd1, 6'd1, 16'h4000, "R12 status unchanged");
        wr(2'd1, 6'd4, 16'hBB00);
        rd_check(2'd1, 6'd0, 16'h4311, "R11 config after soft reset");
        rd_check(2'd1, 6'd1, 16'hA000, "R11 status after soft reset");
        tick(WAIT_N);
        rd_check(2'd1, 6'd1, 16'hA000, "R11 conversion cancelled");

        // R7 precision latched at start (code 3), TEMP2 one-shot
        wr(2'd1, 6'd0, 16'h3300);
        tick(WAIT_N);
        rd_check(2'd1, 6'd1, 16'hA802, "R3 TEMP2 mask");
        wr(2'd1, 6'd0, 16'h7100);
        rd_check(2'd0, 6'd10, 16'h0ABC, "R7 latched precision");
        rd_check(2'd1, 6'd0, 16'h7100, "R2 config rewritten");
        rd_check(2'd1, 6'd1, 16'hA000, "R7 TEMP2 clears bit 1");

        tick(2);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d reads not compared, expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule